// File: doc/BRIEF.md
# Pro-Rated Context Tag Allocator

This block divides a fixed pool of context tags on one link among up to eight device functions. During enumeration each function sends a presence word and then the supported-tag field of each of its accelerators. The block adds these counts into a per-function desired total. Accelerator indices that are missing are never delivered, and nothing has to mark them.

The first query after enumeration starts the allocation. The block adds the desires of all functions. When that sum fits in the pool, every function gets what it asked for. When it does not fit, each grant is scaled down with a multi-cycle sequential divider. Grants are then placed as contiguous ranges in ascending function order. The result is latched. That query and every later one return the base, the granted count, the desired count and the available process-ID count of the selected function.

The controller is a state machine with six states:

- `ST_IDLE` accepts enumeration input. A query moves it to `ST_SUM`.
- `ST_SUM` adds one function's desire per cycle. After the last function it moves to `ST_ALLOC`.
- `ST_ALLOC` handles one function per cycle. A zero desire, or a sum that fits in the pool, stays in `ST_ALLOC`, or moves to `ST_REPLY` after the last function. Scaling moves it to `ST_DIV`.
- `ST_DIV` waits for the divider result. It then returns to `ST_ALLOC`, or moves to `ST_REPLY` after the last function.
- `ST_REPLY` answers the first query and moves to `ST_HOLD`.
- `ST_HOLD` is held until reset and answers each query one cycle later.

Top module: `tag_share_alloc`

## Requirements
- R1: A presence word with bit 31 set marks the function present and takes its highest accelerator index from bits 29:24. Every presence word clears that function's desire to 0.
- R2: An accelerator field adds only its low 12 bits to the function's desire, and only when the function is present and the index is at or below its highest index. Other field entries have no effect.
- R3: A function whose presence word has bit 31 clear keeps a desire of 0, whatever fields it is sent.
- R4: When the summed desire of all functions is 64 or less, each function is granted exactly its desire.
- R5: When the summed desire exceeds 64, each function's grant is floor(64 * desire / sum).
- R6: Bases are assigned in ascending function order from 0, and each function's grant advances the running base. A function with zero desire reports base 0 and grant 0 and does not advance the base.
- R7: The first query raises busy until it completes with a one-cycle done pulse. After that the allocation is held and enumeration input is ignored. Each later query gets done one cycle after it is issued.
- R8: A function with nonzero desire reports a process-ID count of 32767 with invalid low. A function with zero desire reports 0 with invalid high.
- R9: The overflow flag rises when the running base reaches or exceeds 64 after a placement, and it stays high until reset.
- R10: Synchronous reset clears all desires, the held allocation and the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enum_pres_valid | input | 1 | Presence word strobe |
| enum_pres_fn | input | 3 | Function the presence word belongs to |
| enum_pres_word | input | 32 | Presence word (bit 31 present, bits 29:24 highest index) |
| enum_acc_valid | input | 1 | Accelerator field strobe |
| enum_acc_fn | input | 3 | Function owning the accelerator |
| enum_acc_idx | input | 6 | Accelerator index |
| enum_acc_field | input | 16 | Supported-tag field; the low 12 bits are the count |
| qry_valid | input | 1 | Query strobe |
| qry_fn | input | 3 | Function being queried |
| qry_busy | output | 1 | First allocation in progress |
| qry_done | output | 1 | One-cycle pulse: the response fields are valid |
| qry_base | output | 7 | First tag of the function's range |
| qry_grant | output | 7 | Number of tags granted |
| qry_desire | output | 18 | Function's summed desire |
| qry_pid_count | output | 16 | Available process-ID count |
| qry_invalid | output | 1 | Query refers to a function with no desire |
| alloc_overflow | output | 1 | Running base reached the pool size (sticky) |

## Verification
A presence word or accelerator field takes effect at the clock edge that samples it. Its effect on the desire therefore shows in any response loaded after that edge.

The first query has no fixed latency, because each scaled function spends a full divider pass in `ST_DIV`. The bench waits for the done pulse with a bound and checks that busy is high one edge after the query. A later query loads its response registers at the edge that samples it. The bench therefore drives it at a falling edge and reads done and every field at the next falling edge. The overflow flag is read after the first response, when every placement has already been made.

// File: rtl/tag_alloc_pkg.sv
package tag_alloc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SUM,
        ST_ALLOC,
        ST_DIV,
        ST_REPLY,
        ST_HOLD
    } alloc_state_e;

endpackage

// File: rtl/tag_desire_accum.sv
module tag_desire_accum #(
    parameter int NUM_FN   = 8,
    parameter int CNT_W    = 12,
    parameter int IDX_W    = 6,
    parameter int WORD_W   = 32,
    parameter int PRES_BIT = 31,
    parameter int IDX_LSB  = 24,
    parameter int FIELD_W  = 16,
    localparam int FN_W    = $clog2(NUM_FN),
    localparam int DES_W   = CNT_W + IDX_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          en,
    input  logic                          pres_valid,
    input  logic [FN_W-1:0]               pres_fn,
    input  logic [WORD_W-1:0]             pres_word,
    input  logic                          acc_valid,
    input  logic [FN_W-1:0]               acc_fn,
    input  logic [IDX_W-1:0]              acc_idx,
    input  logic [FIELD_W-1:0]            acc_field,
    output logic [NUM_FN-1:0][DES_W-1:0]  desire
);

    for (genvar g = 0; g < NUM_FN; g++) begin : g_fn
        logic             present_q;
        logic [IDX_W-1:0] top_idx_q;
        logic [DES_W-1:0] sum_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                present_q <= 1'b0;
                top_idx_q <= '0;
                sum_q     <= '0;
            end else if (en) begin
                if (pres_valid && pres_fn == FN_W'(g)) begin
                    present_q <= pres_word[PRES_BIT];
                    top_idx_q <= pres_word[IDX_LSB +: IDX_W];
                    sum_q     <= '0;
                end else if (acc_valid && acc_fn == FN_W'(g) && present_q
                             && acc_idx <= top_idx_q) begin
                    sum_q <= sum_q + DES_W'(acc_field[CNT_W-1:0]);
                end
            end
        end

        assign desire[g] = sum_q;
    end

    // R7: with enumeration closed, the desire values must not move
    assert_enum_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(desire));

endmodule

// File: rtl/tag_seq_div.sv
module tag_seq_div #(
    parameter int NUM_W = 28,
    parameter int DEN_W = 21,
    localparam int CW   = $clog2(NUM_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] dividend,
    input  logic [DEN_W-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quotient
);

    logic [DEN_W:0]   rem_q;
    logic [NUM_W-1:0] quo_q;
    logic [CW-1:0]    cnt_q;
    logic             busy_q;
    logic             done_q;
    logic [DEN_W:0]   trial;
    logic             fits;

    assign trial = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
    assign fits  = trial >= {1'b0, divisor};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                rem_q  <= '0;
                quo_q  <= dividend;
                cnt_q  <= CW'(NUM_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= fits ? (trial - {1'b0, divisor}) : trial;
                quo_q <= {quo_q[NUM_W-2:0], fits};
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy     = busy_q;
    assign done     = done_q;
    assign quotient = quo_q;

    // R5: a finished quotient is never reported while a pass is running
    assert_div_idle_on_done_R5: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_q);

endmodule

// File: rtl/tag_share_alloc.sv
module tag_share_alloc #(
    parameter int NUM_FN   = 8,
    parameter int POOL     = 64,
    parameter int CNT_W    = 12,
    parameter int IDX_W    = 6,
    parameter int WORD_W   = 32,
    parameter int PRES_BIT = 31,
    parameter int IDX_LSB  = 24,
    parameter int FIELD_W  = 16,
    parameter int PID_BITS = 15,
    localparam int FN_W    = $clog2(NUM_FN),
    localparam int DES_W   = CNT_W + IDX_W,
    localparam int TOT_W   = DES_W + FN_W,
    localparam int BASE_W  = $clog2(POOL) + 1,
    localparam int NUM_W   = TOT_W + BASE_W,
    localparam int PID_W   = PID_BITS + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enum_pres_valid,
    input  logic [FN_W-1:0]    enum_pres_fn,
    input  logic [WORD_W-1:0]  enum_pres_word,
    input  logic               enum_acc_valid,
    input  logic [FN_W-1:0]    enum_acc_fn,
    input  logic [IDX_W-1:0]   enum_acc_idx,
    input  logic [FIELD_W-1:0] enum_acc_field,
    input  logic               qry_valid,
    input  logic [FN_W-1:0]    qry_fn,
    output logic               qry_busy,
    output logic               qry_done,
    output logic [BASE_W-1:0]  qry_base,
    output logic [BASE_W-1:0]  qry_grant,
    output logic [DES_W-1:0]   qry_desire,
    output logic [PID_W-1:0]   qry_pid_count,
    output logic               qry_invalid,
    output logic               alloc_overflow
);
    import tag_alloc_pkg::*;

    alloc_state_e state_q, state_d;

    logic [NUM_FN-1:0][DES_W-1:0] desire;
    logic [FN_W-1:0]   idx_q;
    logic [FN_W-1:0]   qfn_q;
    logic [TOT_W-1:0]  total_q;
    logic [BASE_W:0]   run_q;
    logic              latched_q;
    logic              ovf_q;
    logic [BASE_W-1:0] base_q  [NUM_FN];
    logic [BASE_W-1:0] grant_q [NUM_FN];

    logic [DES_W-1:0]  des_cur;
    logic              last_fn;
    logic              fits_pool;
    logic              div_start, div_busy, div_done;
    logic [NUM_W-1:0]  div_quo;
    logic [NUM_W-1:0]  dividend;
    logic              place_now;
    logic              step_done;
    logic [BASE_W-1:0] place_cnt;
    logic [BASE_W:0]   run_next;
    logic [FN_W-1:0]   resp_fn;

    tag_desire_accum #(
        .NUM_FN(NUM_FN), .CNT_W(CNT_W), .IDX_W(IDX_W), .WORD_W(WORD_W),
        .PRES_BIT(PRES_BIT), .IDX_LSB(IDX_LSB), .FIELD_W(FIELD_W)
    ) u_accum (
        .clk        (clk),
        .rst        (rst),
        .en         (state_q == ST_IDLE),
        .pres_valid (enum_pres_valid),
        .pres_fn    (enum_pres_fn),
        .pres_word  (enum_pres_word),
        .acc_valid  (enum_acc_valid),
        .acc_fn     (enum_acc_fn),
        .acc_idx    (enum_acc_idx),
        .acc_field  (enum_acc_field),
        .desire     (desire)
    );

    assign des_cur   = desire[idx_q];
    assign last_fn   = (idx_q == FN_W'(NUM_FN - 1));
    assign fits_pool = (total_q <= TOT_W'(POOL));
    assign dividend  = NUM_W'(des_cur) * NUM_W'(POOL);
    assign div_start = (state_q == ST_ALLOC) && (des_cur != '0) && !fits_pool;

    tag_seq_div #(.NUM_W(NUM_W), .DEN_W(TOT_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (dividend),
        .divisor  (total_q),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (div_quo)
    );

    assign place_now = ((state_q == ST_ALLOC) && (des_cur != '0) && fits_pool)
                     || ((state_q == ST_DIV) && div_done);
    assign step_done = ((state_q == ST_ALLOC) && (des_cur == '0)) || place_now;
    assign place_cnt = (state_q == ST_DIV) ? div_quo[BASE_W-1:0] : des_cur[BASE_W-1:0];
    assign run_next  = run_q + (BASE_W + 1)'(place_cnt);
    assign resp_fn   = (state_q == ST_REPLY) ? qfn_q : qry_fn;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (qry_valid) state_d = ST_SUM;
            ST_SUM:   if (last_fn)   state_d = ST_ALLOC;
            ST_ALLOC: begin
                if (des_cur != '0 && !fits_pool) state_d = ST_DIV;
                else if (last_fn)                state_d = ST_REPLY;
            end
            ST_DIV:   if (div_done) state_d = last_fn ? ST_REPLY : ST_ALLOC;
            ST_REPLY: state_d = ST_HOLD;
            ST_HOLD:  state_d = ST_HOLD;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath and response registers
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q         <= '0;
            qfn_q         <= '0;
            total_q       <= '0;
            run_q         <= '0;
            latched_q     <= 1'b0;
            ovf_q         <= 1'b0;
            qry_done      <= 1'b0;
            qry_base      <= '0;
            qry_grant     <= '0;
            qry_desire    <= '0;
            qry_pid_count <= '0;
            qry_invalid   <= 1'b0;
            for (int i = 0; i < NUM_FN; i++) begin
                base_q[i]  <= '0;
                grant_q[i] <= '0;
            end
        end else begin
            qry_done <= 1'b0;
            if (state_q == ST_IDLE && qry_valid) begin
                qfn_q   <= qry_fn;
                idx_q   <= '0;
                total_q <= '0;
                run_q   <= '0;
            end
            if (state_q == ST_SUM) begin
                total_q <= total_q + TOT_W'(des_cur);
                idx_q   <= idx_q + FN_W'(1);
            end
            if (state_q == ST_ALLOC && des_cur == '0) begin
                base_q[idx_q]  <= '0;
                grant_q[idx_q] <= '0;
            end
            if (place_now) begin
                base_q[idx_q]  <= run_q[BASE_W-1:0];
                grant_q[idx_q] <= place_cnt;
                run_q          <= run_next;
                if (run_next >= (BASE_W + 1)'(POOL)) ovf_q <= 1'b1;
            end
            if (step_done) idx_q <= idx_q + FN_W'(1);
            if (state_q == ST_REPLY) latched_q <= 1'b1;
            if (state_q == ST_REPLY || (state_q == ST_HOLD && qry_valid)) begin
                qry_done      <= 1'b1;
                qry_base      <= base_q[resp_fn];
                qry_grant     <= grant_q[resp_fn];
                qry_desire    <= desire[resp_fn];
                qry_invalid   <= (desire[resp_fn] == '0);
                qry_pid_count <= (desire[resp_fn] != '0) ? PID_W'((1 << PID_BITS) - 1) : '0;
            end
        end
    end

    assign qry_busy       = (state_q != ST_IDLE) && (state_q != ST_HOLD);
    assign alloc_overflow = ovf_q;

    // R5: a scaled grant never exceeds the pool
    assert_grant_bound_R5: assert property (@(posedge clk) disable iff (rst)
        div_done |-> div_quo <= NUM_W'(POOL));

    // R4: a grant never exceeds the desire it answers
    assert_grant_le_desire_R4: assert property (@(posedge clk) disable iff (rst)
        qry_done |-> DES_W'(qry_grant) <= qry_desire);

    // R7: once latched, the allocation stays latched
    assert_latch_held_R7: assert property (@(posedge clk) disable iff (rst)
        latched_q |=> latched_q);

    // R7: a response is never given while the allocation is running
    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
        qry_done |-> !qry_busy);

    // R8: invalid and a nonzero process-ID count exclude each other
    assert_pid_invalid_R8: assert property (@(posedge clk) disable iff (rst)
        qry_done |-> (qry_invalid != (qry_pid_count != '0)));

    // R9: the overflow flag is sticky
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);

endmodule

// File: tb/tb_tag_share_alloc.sv
`timescale 1ns/1ps
module tb_tag_share_alloc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enum_pres_valid = 1'b0;
    logic [2:0]  enum_pres_fn = '0;
    logic [31:0] enum_pres_word = '0;
    logic        enum_acc_valid = 1'b0;
    logic [2:0]  enum_acc_fn = '0;
    logic [5:0]  enum_acc_idx = '0;
    logic [15:0] enum_acc_field = '0;
    logic        qry_valid = 1'b0;
    logic [2:0]  qry_fn = '0;
    logic        qry_busy, qry_done, qry_invalid, alloc_overflow;
    logic [6:0]  qry_base, qry_grant;
    logic [17:0] qry_desire;
    logic [15:0] qry_pid_count;

    int checks = 0;
    int errors = 0;
    int m_pres [8];
    int m_max  [8];
    longint m_des [8];
    bit frozen = 0;

    always #4 clk = ~clk;

    tag_share_alloc dut (
        .clk(clk), .rst(rst),
        .enum_pres_valid(enum_pres_valid), .enum_pres_fn(enum_pres_fn),
        .enum_pres_word(enum_pres_word), .enum_acc_valid(enum_acc_valid),
        .enum_acc_fn(enum_acc_fn), .enum_acc_idx(enum_acc_idx),
        .enum_acc_field(enum_acc_field), .qry_valid(qry_valid), .qry_fn(qry_fn),
        .qry_busy(qry_busy), .qry_done(qry_done), .qry_base(qry_base),
        .qry_grant(qry_grant), .qry_desire(qry_desire),
        .qry_pid_count(qry_pid_count), .qry_invalid(qry_invalid),
        .alloc_overflow(alloc_overflow)
    );

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        frozen = 0;
        for (int f = 0; f < 8; f++) begin
            m_pres[f] = 0; m_max[f] = 0; m_des[f] = 0;
        end
        // R10: reset state
        chk(qry_busy == 1'b0, "R10", "busy after reset", qry_busy, 0);
        chk(qry_done == 1'b0, "R10", "done after reset", qry_done, 0);
        chk(alloc_overflow == 1'b0, "R10", "overflow after reset", alloc_overflow, 0);
    endtask

    task automatic set_pres(int f, bit p, int mx);
        @(negedge clk);
        enum_pres_valid = 1'b1;
        enum_pres_fn    = 3'(f);
        enum_pres_word  = {p, 1'b1, 6'(mx), 24'hA5C35A};
        @(negedge clk);
        enum_pres_valid = 1'b0;
        if (!frozen) begin
            m_pres[f] = p; m_max[f] = mx; m_des[f] = 0;
        end
    endtask

    task automatic add_acc(int f, int idx, int field);
        @(negedge clk);
        enum_acc_valid = 1'b1;
        enum_acc_fn    = 3'(f);
        enum_acc_idx   = 6'(idx);
        enum_acc_field = 16'(field);
        @(negedge clk);
        enum_acc_valid = 1'b0;
        if (!frozen && m_pres[f] != 0 && idx <= m_max[f])
            m_des[f] += (field & 'hFFF);
    endtask

    task automatic expect_alloc(output longint eb[8], output longint eg[8],
                                output bit eovf, output longint tot);
        longint run;
        tot = 0; run = 0; eovf = 0;
        for (int f = 0; f < 8; f++) tot += m_des[f];
        for (int f = 0; f < 8; f++) begin
            if (m_des[f] == 0) begin
                eb[f] = 0; eg[f] = 0;
            end else begin
                eg[f] = (tot <= 64) ? m_des[f] : (64 * m_des[f]) / tot;
                eb[f] = run;
                run += eg[f];
                if (run >= 64) eovf = 1;
            end
        end
    endtask

    task automatic compare(int f);
        longint eb[8], eg[8], tot;
        bit eovf;
        expect_alloc(eb, eg, eovf, tot);
        chk(qry_desire == 18'(m_des[f]), (m_pres[f] != 0) ? "R2" : "R3",
            $sformatf("desire fn%0d", f), qry_desire, m_des[f]);
        chk(qry_grant == 7'(eg[f]), (tot <= 64) ? "R4" : "R5",
            $sformatf("grant fn%0d", f), qry_grant, eg[f]);
        chk(qry_base == 7'(eb[f]), "R6", $sformatf("base fn%0d", f), qry_base, eb[f]);
        chk(qry_pid_count == ((m_des[f] != 0) ? 16'd32767 : 16'd0), "R8",
            $sformatf("pid count fn%0d", f), qry_pid_count, (m_des[f] != 0) ? 32767 : 0);
        chk(qry_invalid == (m_des[f] == 0), "R8", $sformatf("invalid fn%0d", f),
            qry_invalid, m_des[f] == 0);
    endtask

    task automatic first_query(int f);
        int n;
        longint eb[8], eg[8], tot;
        bit eovf;
        @(negedge clk);
        qry_valid = 1'b1; qry_fn = 3'(f);
        @(negedge clk);
        qry_valid = 1'b0;
        chk(qry_busy == 1'b1, "R7", "busy after first query", qry_busy, 1);
        n = 0;
        while (!qry_done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(qry_done == 1'b1, "R7", "first query completion", qry_done, 1);
        frozen = 1;
        compare(f);
        expect_alloc(eb, eg, eovf, tot);
        chk(alloc_overflow == eovf, "R9", "overflow flag", alloc_overflow, eovf);
    endtask

    task automatic query(int f);
        @(negedge clk);
        qry_valid = 1'b1; qry_fn = 3'(f);
        @(negedge clk);
        qry_valid = 1'b0;
        chk(qry_done == 1'b1, "R7", $sformatf("one-cycle answer fn%0d", f), qry_done, 1);
        compare(f);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        do_reset();

        // R1: a new presence word clears the earlier desire
        set_pres(0, 1, 3);
        add_acc(0, 0, 5);
        set_pres(0, 1, 3);
        add_acc(0, 1, 16'hF007);
        add_acc(0, 4, 9);
        first_query(0);
        chk(qry_desire == 18'd7, "R1", "desire after re-presence", qry_desire, 7);
        for (int f = 0; f < 8; f++) query(f);

        // R4 / R9: a sum of exactly 64 fills the pool and raises overflow
        do_reset();
        set_pres(2, 1, 0);
        add_acc(2, 0, 64);
        first_query(2);
        for (int f = 0; f < 8; f++) query(f);

        // R5: a large desire beside a tiny one gives a zero grant
        do_reset();
        set_pres(1, 1, 0);
        add_acc(1, 0, 16'hFFFF);
        set_pres(4, 1, 0);
        add_acc(4, 0, 1);
        first_query(4);
        for (int f = 0; f < 8; f++) query(f);

        // sweep of mixed configurations
        for (int s = 0; s < 12; s++) begin
            do_reset();
            for (int f = 0; f < 8; f++) begin
                automatic bit p  = ((s + f) % 3) != 0;
                automatic int mx = (s + f) % 4;
                set_pres(f, p, mx);
                for (int i = 0; i <= mx + 1; i++) begin
                    automatic int fld = (s % 2 == 0) ? ((s + f + i) % 4)
                                                     : ((s * 7 + f * 13 + i * 5) % 40);
                    add_acc(f, i, 16'hB000 | fld);
                end
            end
            first_query(s % 8);
            for (int f = 0; f < 8; f++) query(f);
            // R7: enumeration after the allocation is latched has no effect
            set_pres(0, 1, 5);
            add_acc(0, 0, 100);
            query(0);
        end

        // R10: after reset, nothing remains of the old allocation
        do_reset();
        first_query(3);
        chk(qry_invalid == 1'b1, "R10", "desire cleared by reset", qry_invalid, 1);

        summary();
        $finish;
    end

endmodule